// File: doc/BRIEF.md
# Main Clock Loss Monitor with Power-Mode Suspension

This block watches a main clock from a free-running internal sampling clock and raises a reset request when the main clock stops without warning. A toggle flip-flop clocked by the main clock is carried into the sampling domain. A counter there measures how many sampling cycles pass without a toggle edge. When the gap reaches a set limit, the block issues a single-cycle reset request.

Software arms the block with a write of 1 to its enable bit. The bit stays set until system reset. Detection is suspended when the main clock is stopped on purpose or cannot be checked. This covers STOP mode, the stabilization wait after STOP release, a main clock turned off on purpose, the CPU running from the internal oscillator, and a halted sampling clock. The detection counter is held at zero for as long as the suspension lasts. All control flags pass through two-flop synchronizers into the sampling domain. The enable write port is synchronous to the sampling clock.

Top module: `mclk_loss_mon`

## Requirements
- R1: While rst_ni is low, and after release until the block is armed, loss_rst_o and mon_active_o are 0, and a stopped main clock raises no request.
- R2: A cycle with arm_wr_i=1 and arm_wdata_i=1 arms the block. mon_active_o is 1 while the block is armed and no suspend input is active.
- R3: A write with arm_wdata_i=0 is ignored. Once armed, the block stays armed until system reset.
- R4: When armed and not suspended, a request is raised once LOSS_CYCLES (default 4) consecutive sampling cycles pass with no observed main-clock edge. A main clock of period 4 sampling cycles causes no request. A period of 5 sampling cycles, or a stopped clock, causes a request.
- R5: stop_mode_i=1 suspends detection and drives mon_active_o to 0.
- R6: stab_busy_i=1 (stabilization count after STOP release) suspends detection.
- R7: main_off_i=1 (main clock intentionally stopped) suspends detection.
- R8: cpu_int_osc_i=1 (CPU running from the internal oscillator) suspends detection.
- R9: sclk_run_i=0 (sampling oscillator halted) suspends detection.
- R10: The gap counter is held at zero during suspension. Active windows of 2 cycles separated by suspension never add up to a request.
- R11: loss_rst_o is a one-cycle pulse. It fires at most once between system resets, even across later loss events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Internal sampling clock |
| rst_ni | input | 1 | System reset, active low, asynchronous |
| mclk_i | input | 1 | Monitored main clock |
| sclk_run_i | input | 1 | Sampling oscillator running indicator |
| arm_wr_i | input | 1 | Enable register write strobe (sampling domain) |
| arm_wdata_i | input | 1 | Enable write data |
| stop_mode_i | input | 1 | STOP mode active |
| stab_busy_i | input | 1 | Oscillation stabilization count in progress |
| main_off_i | input | 1 | Main clock intentionally stopped |
| cpu_int_osc_i | input | 1 | CPU clocked from internal oscillator |
| loss_rst_o | output | 1 | Clock-loss reset request pulse |
| mon_active_o | output | 1 | Monitor armed and not suspended |

## Verification
The bench builds the block with its defaults: a loss limit of 4 cycles and 2 synchronizer stages. With these values the detection threshold sits between main-clock periods of 40 ns and 50 ns against a 10 ns sampling clock, so both sides of the boundary can be driven exactly. The short limit also lets a 2-cycle on/2-cycle off suspension pattern run long enough to expose any count that survives a suspension.

// File: rtl/mlm_pkg.sv
package mlm_pkg;
    parameter int DEF_LOSS_CYCLES = 4;
    parameter int DEF_SYNC_STAGES = 2;

    // bit positions of the suspend sources inside the synchronized vector
    typedef enum int {
        SUSP_SCLK_HALT = 0,
        SUSP_STOP      = 1,
        SUSP_STAB      = 2,
        SUSP_MAIN_OFF  = 3,
        SUSP_CPU_INT   = 4
    } susp_idx_e;

    parameter int SUSP_N = 5;
endpackage

// File: rtl/mlm_sync.sv
module mlm_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] din_i,
    output logic [WIDTH-1:0] dout_o
);
    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk_i or negedge rst_ni) begin
                if (!rst_ni) stage_q[g] <= '0;
                else         stage_q[g] <= stage_d[g];
            end
        end
    endgenerate

    assign dout_o = stage_q[STAGES-1];
endmodule

// File: rtl/mlm_toggle.sv
module mlm_toggle (
    input  logic mclk_i,
    input  logic rst_ni,
    output logic tog_o
);
    logic tog_d, tog_q;

    always_comb tog_d = ~tog_q;

    always_ff @(posedge mclk_i or negedge rst_ni) begin
        if (!rst_ni) tog_q <= 1'b0;
        else         tog_q <= tog_d;
    end

    assign tog_o = tog_q;
endmodule

// File: rtl/mlm_core.sv
module mlm_core #(
    parameter int LOSS_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic arm_set_i,
    input  logic tog_i,
    input  logic suspend_i,
    output logic active_o,
    output logic loss_o
);
    localparam int CW = $clog2(LOSS_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(LOSS_CYCLES - 1);

    typedef struct packed {
        logic          armed;
        logic          fired;
        logic          loss;
        logic          tog_prev;
        logic [CW-1:0] cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     active;
    logic     seen_edge;

    always_comb begin
        st_d       = st_q;
        active     = st_q.armed & ~suspend_i;
        seen_edge  = tog_i ^ st_q.tog_prev;
        st_d.loss  = 1'b0;
        st_d.tog_prev = tog_i;
        if (arm_set_i) st_d.armed = 1'b1;
        if (!active || seen_edge) begin
            st_d.cnt = '0;
        end else if (st_q.cnt == LAST) begin
            if (!st_q.fired) begin
                st_d.loss  = 1'b1;
                st_d.fired = 1'b1;
            end
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign active_o = active;
    assign loss_o   = st_q.loss;
endmodule

// File: rtl/mclk_loss_mon.sv
module mclk_loss_mon
    import mlm_pkg::*;
#(
    parameter int LOSS_CYCLES = DEF_LOSS_CYCLES,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic sclk_i,
    input  logic rst_ni,
    input  logic mclk_i,
    input  logic sclk_run_i,
    input  logic arm_wr_i,
    input  logic arm_wdata_i,
    input  logic stop_mode_i,
    input  logic stab_busy_i,
    input  logic main_off_i,
    input  logic cpu_int_osc_i,
    output logic loss_rst_o,
    output logic mon_active_o
);
    logic [SUSP_N-1:0] susp_raw, susp_sync;
    logic              tog_m, tog_s;

    always_comb begin
        susp_raw                 = '0;
        susp_raw[SUSP_SCLK_HALT] = ~sclk_run_i;
        susp_raw[SUSP_STOP]      = stop_mode_i;
        susp_raw[SUSP_STAB]      = stab_busy_i;
        susp_raw[SUSP_MAIN_OFF]  = main_off_i;
        susp_raw[SUSP_CPU_INT]   = cpu_int_osc_i;
    end

    mlm_toggle u_tog (
        .mclk_i (mclk_i),
        .rst_ni (rst_ni),
        .tog_o  (tog_m)
    );

    mlm_sync #(.WIDTH(1), .STAGES(SYNC_STAGES)) u_tog_sync (
        .clk_i  (sclk_i),
        .rst_ni (rst_ni),
        .din_i  (tog_m),
        .dout_o (tog_s)
    );

    mlm_sync #(.WIDTH(SUSP_N), .STAGES(SYNC_STAGES)) u_susp_sync (
        .clk_i  (sclk_i),
        .rst_ni (rst_ni),
        .din_i  (susp_raw),
        .dout_o (susp_sync)
    );

    mlm_core #(.LOSS_CYCLES(LOSS_CYCLES)) u_core (
        .clk_i     (sclk_i),
        .rst_ni    (rst_ni),
        .arm_set_i (arm_wr_i & arm_wdata_i),
        .tog_i     (tog_s),
        .suspend_i (|susp_sync),
        .active_o  (mon_active_o),
        .loss_o    (loss_rst_o)
    );
endmodule

// File: rtl/mclk_loss_mon_chk.sv
module mclk_loss_mon_chk (
    input logic sclk_i,
    input logic rst_ni,
    input logic arm_wr_i,
    input logic arm_wdata_i,
    input logic loss_rst_o,
    input logic mon_active_o
);
    logic armed_seen_q, fired_seen_q;

    always_ff @(posedge sclk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            armed_seen_q <= 1'b0;
            fired_seen_q <= 1'b0;
        end else begin
            if (arm_wr_i && arm_wdata_i) armed_seen_q <= 1'b1;
            if (loss_rst_o)              fired_seen_q <= 1'b1;
        end
    end

    // R11
    pulse_width_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        loss_rst_o |=> !loss_rst_o);

    // R11
    single_fire_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        loss_rst_o |-> !fired_seen_q);

    // R4
    loss_when_active_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        loss_rst_o |-> $past(mon_active_o));

    // R2
    active_needs_arm_chk: assert property (@(posedge sclk_i) disable iff (!rst_ni)
        mon_active_o |-> armed_seen_q);
endmodule

bind mclk_loss_mon mclk_loss_mon_chk chk_i (
    .sclk_i       (sclk_i),
    .rst_ni       (rst_ni),
    .arm_wr_i     (arm_wr_i),
    .arm_wdata_i  (arm_wdata_i),
    .loss_rst_o   (loss_rst_o),
    .mon_active_o (mon_active_o)
);

// File: tb/mclk_loss_mon_tb_top.sv
module mclk_loss_mon_tb_top;
    logic sclk, rst_n, mclk, sclk_run, arm_wr, arm_wdata;
    logic stop_mode, stab_busy, main_off, cpu_int;
    logic loss, active;
    int   mclk_half;
    int   errors, checks, pulses, wide;
    logic loss_prev;

    // susp bits: [0] stop, [1] stab, [2] main_off, [3] cpu_int, [4] sclk halted
    typedef struct packed {
        logic [7:0] half;
        logic [4:0] susp;
        logic       pulse;
        logic       act;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{8'd5,  5'b00000, 1'b0, 1'b1},
        '{8'd20, 5'b00000, 1'b0, 1'b1},
        '{8'd25, 5'b00000, 1'b1, 1'b1},
        '{8'd0,  5'b00000, 1'b1, 1'b1},
        '{8'd0,  5'b00001, 1'b0, 1'b0},
        '{8'd0,  5'b00010, 1'b0, 1'b0},
        '{8'd0,  5'b00100, 1'b0, 1'b0},
        '{8'd0,  5'b01000, 1'b0, 1'b0},
        '{8'd0,  5'b10000, 1'b0, 1'b0}
    };
    localparam string VTAG [NV] = '{"R4", "R4", "R4", "R4", "R5", "R6", "R7", "R8", "R9"};

    mclk_loss_mon dut_i (
        .sclk_i(sclk), .rst_ni(rst_n), .mclk_i(mclk), .sclk_run_i(sclk_run),
        .arm_wr_i(arm_wr), .arm_wdata_i(arm_wdata), .stop_mode_i(stop_mode),
        .stab_busy_i(stab_busy), .main_off_i(main_off), .cpu_int_osc_i(cpu_int),
        .loss_rst_o(loss), .mon_active_o(active)
    );

    initial begin
        sclk = 1'b0;
        forever #5 sclk = ~sclk;
    end

    initial begin
        mclk = 1'b0;
        forever begin
            wait (mclk_half != 0);
            #2;
            while (mclk_half != 0) begin
                #(mclk_half) mclk = ~mclk;
            end
        end
    end

    always @(negedge sclk) begin
        if (rst_n && loss) pulses <= pulses + 1;
        if (rst_n && loss && loss_prev) wide <= wide + 1;
        loss_prev <= loss;
    end

    task automatic check(input string tag, input int act_v, input int exp_v);
        checks++;
        if (act_v != exp_v) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", tag, act_v, exp_v);
        end
    endtask

    task automatic set_susp(input logic [4:0] s);
        stop_mode = s[0];
        stab_busy = s[1];
        main_off  = s[2];
        cpu_int   = s[3];
        sclk_run  = ~s[4];
    endtask

    task automatic restart(input logic [4:0] s, input int half);
        rst_n = 1'b0;
        arm_wr = 1'b0;
        arm_wdata = 1'b0;
        set_susp(s);
        mclk_half = half;
        repeat (3) @(negedge sclk);
        rst_n = 1'b1;
        repeat (3) @(negedge sclk);
    endtask

    task automatic write_arm(input logic v);
        arm_wr = 1'b1;
        arm_wdata = v;
        @(negedge sclk);
        arm_wr = 1'b0;
        arm_wdata = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int base;
        errors = 0; checks = 0; pulses = 0; wide = 0; loss_prev = 1'b0;
        mclk_half = 0;
        rst_n = 1'b0; arm_wr = 1'b0; arm_wdata = 1'b0;
        set_susp(5'b0);
        repeat (3) @(negedge sclk);
        // R1: reset state
        check("R1 loss in reset", int'(loss), 0);
        check("R1 active in reset", int'(active), 0);

        // R1: not armed, stopped clock, no request
        restart(5'b0, 0);
        base = pulses;
        repeat (40) @(negedge sclk);
        check("R1 unarmed pulses", pulses - base, 0);
        check("R1 unarmed active", int'(active), 0);

        for (int i = 0; i < NV; i++) begin
            restart(VEC[i].susp, int'(VEC[i].half));
            base = pulses;
            write_arm(1'b1);
            repeat (40) @(negedge sclk);
            check({VTAG[i], " vector pulses"}, pulses - base, int'(VEC[i].pulse));
            check({"R2 vector active ", VTAG[i]}, int'(active), int'(VEC[i].act));
        end

        // R3: clearing write is ignored
        restart(5'b0, 5);
        write_arm(1'b1);
        repeat (3) @(negedge sclk);
        write_arm(1'b0);
        repeat (3) @(negedge sclk);
        check("R3 active after clear write", int'(active), 1);
        base = pulses;
        mclk_half = 0;
        repeat (40) @(negedge sclk);
        check("R3 still detects", pulses - base, 1);

        // R11: no second request after recovery and a new loss
        base = pulses;
        mclk_half = 5;
        repeat (30) @(negedge sclk);
        mclk_half = 0;
        repeat (40) @(negedge sclk);
        check("R11 second event", pulses - base, 0);
        check("R11 pulse width", wide, 0);

        // R10: short active windows between suspensions never accumulate
        restart(5'b00010, 0);
        write_arm(1'b1);
        base = pulses;
        for (int k = 0; k < 10; k++) begin
            stab_busy = 1'b0;
            repeat (2) @(negedge sclk);
            stab_busy = 1'b1;
            repeat (2) @(negedge sclk);
        end
        repeat (4) @(negedge sclk);
        check("R10 chopped windows", pulses - base, 0);
        stab_busy = 1'b0;
        repeat (12) @(negedge sclk);
        check("R10 after release", pulses - base, 1);

        // R5: active drops when a suspend source rises while armed
        stop_mode = 1'b1;
        repeat (4) @(negedge sclk);
        check("R5 active in stop", int'(active), 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule